// File: doc/BRIEF.md
# Dual-Mode Bit Rate Generator

This block turns the system clock into a one-clock-wide bit tick that paces a serial bus. A second one-clock-wide tick falls near the middle of each bit, for sampling the return line. The block has two ways of setting the rate. In integer mode, every bit lasts a base of 27 clocks multiplied by a programmable whole-number divider. In spread mode, the rate is the clock divided by 33 and then raised by a factor of (1 + offset/512). A fractional accumulator produces that rate, and the divider plays no part in it.

The mode, divider and offset inputs can change at any time. The block takes them in only while it is disabled, or at the clock edge that ends a bit. A bit that has already started therefore keeps the length it started with. Dropping the enable stops both ticks and returns the timing to the start of a bit.

Top module: `bit_rate_gen`

## Requirements
- R1: In integer mode with divider n ≥ 1 and period P = 27·n, `bit_tick` is high in enabled cycle P−1 and every P cycles after that. Enabled cycles are numbered from 0, and cycle 0 is the first cycle with `enable` high after the configuration was taken in.
- R2: A divider value of 0 gives the same timing as a divider value of 1, a period of 27 clocks.
- R3: In spread mode (`mode_spread` = 1), an accumulator starts at 0 and adds 512 + offset in every enabled cycle. `bit_tick` is high in a cycle when the running sum reaches 16896 or more, and 16896 is then subtracted. Over the first N enabled cycles the tick count is therefore floor(N·(512+offset)/16896).
- R4: In spread mode the value on `divider` has no effect on either tick.
- R5: In integer mode, `mid_tick` is high in enabled cycle H−1 and every P cycles after that, where H = floor(P/2). Each mid tick therefore comes H cycles after a bit tick.
- R6: In spread mode, `mid_tick` is high in a cycle when the running sum crosses 8448 from below. Over the first N enabled cycles its count is floor((N·(512+offset) + 8448)/16896).
- R7: `mode_spread`, `divider` and `offset` are taken in only at a clock edge where `enable` is low or `bit_tick` is high. A change made in the middle of a bit first affects the bit that follows.
- R8: While `enable` is low, neither tick is raised. After `enable` is raised again, timing restarts from enabled cycle 0.
- R9: Each tick lasts one clock, and `bit_tick` and `mid_tick` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| enable | input | 1 | Runs the generator; while low, the timing is held at the start of a bit and the configuration is taken in |
| mode_spread | input | 1 | 0 = integer divider mode, 1 = spread (fractional) mode |
| divider | input | DIV_W (8) | Integer divider n; a value of 0 acts as 1 |
| offset | input | OFS_W (8) | Spread-mode rate offset, in units of 1/512 |
| bit_tick | output | 1 | One-clock pulse at each bit boundary |
| mid_tick | output | 1 | One-clock pulse near the middle of each bit |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in the middle of a bit. The change must be held off until the tick edge and then take effect at once, and that shows up only in where later ticks land. The bench starts a bit with a divider of 2, changes the divider to 1 ten cycles in, and checks three things: the first bit tick still lands at cycle 53, the next one follows 27 cycles later, and the mid tick moves to the new half-period. For spread mode, the bench counts ticks over a window of 8448 cycles, where the floor formula gives an exact count. This shows the accumulator remainder is carried from bit to bit.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic {
    MODE_DIV    = 1'b0,
    MODE_SPREAD = 1'b1
  } brg_mode_e;
endpackage

// File: rtl/brg_cfg_latch.sv
// Holds the working configuration; reloads only when told to.
module brg_cfg_latch
  import brg_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OFS_W     = 8,
  parameter int BASE      = 27,
  parameter int FRAC_BITS = 9,
  parameter int PW        = 13,
  parameter int SW        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mode_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic [OFS_W-1:0] ofs_in,
  output brg_mode_e        mode_q,
  output logic [PW-1:0]    period_q,
  output logic [PW-1:0]    half_q,
  output logic [SW-1:0]    step_q
);
  localparam logic [PW-1:0] BASE_P = PW'(BASE);
  localparam logic [SW-1:0] UNITY  = SW'(1 << FRAC_BITS);

  logic [DIV_W-1:0] n_eff;
  logic [PW-1:0]    period_d;
  logic [SW-1:0]    step_d;
  brg_mode_e        mode_d;

  always_comb begin
    n_eff    = (div_in == '0) ? DIV_W'(1) : div_in;
    period_d = BASE_P * PW'(n_eff);
    step_d   = UNITY + SW'(ofs_in);
    mode_d   = mode_in ? MODE_SPREAD : MODE_DIV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_DIV;
      period_q <= BASE_P;
      half_q   <= BASE_P >> 1;
      step_q   <= UNITY;
    end else if (load) begin
      mode_q   <= mode_d;
      period_q <= period_d;
      half_q   <= period_d >> 1;
      step_q   <= step_d;
    end
  end
endmodule

// File: rtl/brg_int_div.sv
// Integer-mode bit timer: counts through one period of 27*n clocks.
module brg_int_div #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  input  logic [PW-1:0] half,
  output logic          bit_pulse,
  output logic          mid_pulse
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end    = (cnt_q == period - PW'(1));
    bit_pulse = run && at_end;
    mid_pulse = run && (cnt_q == half - PW'(1));
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/brg_frac_acc.sv
// Spread-mode bit timer: fractional accumulator with remainder carry.
module brg_frac_acc #(
  parameter int FRAC_BITS = 9,
  parameter int DEN       = 33,
  parameter int SW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] step,
  output logic          bit_pulse,
  output logic          mid_pulse
);
  localparam int LIM   = DEN << FRAC_BITS;
  localparam int HALF  = LIM / 2;
  localparam int ACC_W = $clog2(LIM + (2 << FRAC_BITS));
  localparam logic [ACC_W-1:0] LIM_A  = ACC_W'(LIM);
  localparam logic [ACC_W-1:0] HALF_A = ACC_W'(HALF);

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum       = acc_q + ACC_W'(step);
    bit_pulse = run && (sum >= LIM_A);
    mid_pulse = run && (acc_q < HALF_A) && (sum >= HALF_A);
    if (!run)           acc_d = '0;
    else if (bit_pulse) acc_d = sum - LIM_A;
    else                acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/bit_rate_gen.sv
module bit_rate_gen
  import brg_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int OFS_W     = 8,
  parameter int BASE      = 27,
  parameter int DEN       = 33,
  parameter int FRAC_BITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_spread,
  input  logic [DIV_W-1:0] divider,
  input  logic [OFS_W-1:0] offset,
  output logic             bit_tick,
  output logic             mid_tick
);
  localparam int PW = DIV_W + $clog2(BASE + 1);
  localparam int SW = FRAC_BITS + 1;

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          cfg_load;
  brg_mode_e     mode_q;
  logic [PW-1:0] period_q, half_q;
  logic [SW-1:0] step_q;
  logic          run_div, run_spr;
  logic          div_bit, div_mid, spr_bit, spr_mid;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cfg_load = !enable || bit_tick;
  assign run_div  = enable && (mode_q == MODE_DIV);
  assign run_spr  = enable && (mode_q == MODE_SPREAD);

  brg_cfg_latch #(
    .DIV_W(DIV_W), .OFS_W(OFS_W), .BASE(BASE),
    .FRAC_BITS(FRAC_BITS), .PW(PW), .SW(SW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .load(cfg_load),
    .mode_in(mode_spread), .div_in(divider), .ofs_in(offset),
    .mode_q(mode_q), .period_q(period_q), .half_q(half_q), .step_q(step_q)
  );

  brg_int_div #(.PW(PW)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(run_div),
    .period(period_q), .half(half_q),
    .bit_pulse(div_bit), .mid_pulse(div_mid)
  );

  brg_frac_acc #(.FRAC_BITS(FRAC_BITS), .DEN(DEN), .SW(SW)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .run(run_spr), .step(step_q),
    .bit_pulse(spr_bit), .mid_pulse(spr_mid)
  );

  assign bit_tick = div_bit || spr_bit;
  assign mid_tick = div_mid || spr_mid;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int PW = 13,
  parameter int SW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          bit_tick,
  input logic          mid_tick,
  input logic          cfg_load,
  input logic          mode_q,
  input logic [PW-1:0] period_q,
  input logic [SW-1:0] step_q
);
  // R9
  tick_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && mid_tick));

  // R9
  bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R9
  mid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |=> !mid_tick);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!bit_tick && !mid_tick));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(mode_q) && $stable(period_q) && $stable(step_q)));
endmodule

bind bit_rate_gen brg_checker #(.PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .enable(enable),
  .bit_tick(bit_tick), .mid_tick(mid_tick), .cfg_load(cfg_load),
  .mode_q(mode_q), .period_q(period_q), .step_q(step_q)
);

// File: tb/bit_rate_gen_test.sv
module bit_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       mode_spread;
  logic [7:0] divider;
  logic [7:0] offset;
  logic       bit_tick, mid_tick;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bit_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_spread(mode_spread),
    .divider(divider), .offset(offset), .bit_tick(bit_tick), .mid_tick(mid_tick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Load config with enable low, then run N enabled cycles, recording tick positions.
  task automatic run_window(input bit spr, input int dv, input int of, input int n,
                            output int b0, output int b1, output int m0,
                            output int nb, output int nm);
    b0 = -1; b1 = -1; m0 = -1; nb = 0; nm = 0;
    @(negedge clk);
    enable = 0; mode_spread = spr; divider = 8'(dv); offset = 8'(of);
    @(negedge clk);
    enable = 1;
    #1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      if (bit_tick) begin
        if (b0 < 0) b0 = k; else if (b1 < 0) b1 = k;
        nb++;
      end
      if (mid_tick) begin
        if (m0 < 0) m0 = k;
        nm++;
      end
    end
    @(negedge clk);
    enable = 0;
  endtask

  task automatic test_reset();
    rst_n = 0; enable = 0; mode_spread = 0; divider = 8'd1; offset = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    check(bit_tick == 1'b0, "R8 reset bit_tick", bit_tick, 0);
    check(mid_tick == 1'b0, "R8 reset mid_tick", mid_tick, 0);
  endtask

  task automatic test_normal(input int dv);
    int p, h, b0, b1, m0, nb, nm, n;
    p = 27 * ((dv == 0) ? 1 : dv);
    h = p / 2;
    n = 3 * p + 5;
    run_window(1'b0, dv, 0, n, b0, b1, m0, nb, nm);
    check(b0 == p - 1, (dv == 0) ? "R2 first bit tick" : "R1 first bit tick", b0, p - 1);
    check(b1 == 2 * p - 1, "R1 second bit tick", b1, 2 * p - 1);
    check(nb == n / p, "R1 bit tick count", nb, n / p);
    check(m0 == h - 1, "R5 first mid tick", m0, h - 1);
    check(nm == (n - h) / p + 1, "R5 mid tick count", nm, (n - h) / p + 1);
  endtask

  task automatic test_spread(input int of, input int dv);
    int b0, b1, m0, nb, nm, n;
    longint s, eb, em;
    n  = 8448;
    s  = longint'(n) * (512 + of);
    eb = s / 16896;
    em = (s + 8448) / 16896;
    run_window(1'b1, dv, of, n, b0, b1, m0, nb, nm);
    if (dv != 1) check(nb == eb, "R4 bit count with divider set", nb, eb);
    else         check(nb == eb, "R3 spread bit count", nb, eb);
    check(nm == em, "R6 spread mid count", nm, em);
  endtask

  // Divider changed mid-bit: takes effect only after the current bit.
  task automatic test_latch();
    int b0, b1, m0, m1;
    b0 = -1; b1 = -1; m0 = -1; m1 = -1;
    @(negedge clk);
    enable = 0; mode_spread = 0; divider = 8'd2; offset = 8'd0;
    @(negedge clk);
    enable = 1;
    #1;
    for (int k = 0; k < 100; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      if (k == 10) divider = 8'd1;
      if (bit_tick) begin if (b0 < 0) b0 = k; else if (b1 < 0) b1 = k; end
      if (mid_tick) begin if (m0 < 0) m0 = k; else if (m1 < 0) m1 = k; end
    end
    @(negedge clk);
    enable = 0;
    check(b0 == 53, "R7 current bit keeps old period", b0, 53);
    check(b1 == 80, "R7 next bit uses new period", b1, 80);
    check(m1 == 66, "R7 mid tick follows new period", m1, 66);
  endtask

  task automatic test_disable();
    int seen, b0;
    seen = 0; b0 = -1;
    @(negedge clk);
    enable = 0; mode_spread = 0; divider = 8'd1;
    @(negedge clk);
    enable = 1;
    repeat (15) @(negedge clk);
    enable = 0;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (bit_tick || mid_tick) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 no ticks while disabled", seen, 0);
    enable = 1;
    #1;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      if (bit_tick && b0 < 0) b0 = k;
    end
    @(negedge clk);
    enable = 0;
    check(b0 == 26, "R8 restart from cycle 0", b0, 26);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_normal(1);
        test_normal(3);
        test_normal(0);
        test_latch();
        test_disable();
        test_spread(0, 1);
        test_spread(63, 1);
        test_spread(122, 1);
        test_spread(159, 1);
        test_spread(255, 1);
        test_spread(63, 200);
      end
      begin
        wait (cyc >= 150000);
        check(1'b0, "watchdog expired", cyc, 150000);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule